// File: doc/BRIEF.md
# Bitwise Logic and Extension Unit

This execution unit serves a 32-bit RISC core. It takes an operation that has already been decoded, two source register values, the index of the first source register, a 16-bit immediate and a record bit. It produces a 32-bit result, a register write enable and an optional update of condition field 0. The unit covers three groups of work:

- the eight register-to-register bitwise operations, including the forms that use a complemented operand;
- the AND, OR and XOR immediate forms, in low and high variants, and sign extension of a byte or a halfword;
- the two add-immediate forms that compilers use to build constants.

Outputs are registered and appear one cycle after an input is accepted, together with a valid strobe.

Each operation has its own flag rule:

- The register-to-register logic operations and the sign extensions write the condition field only when the record bit is set.
- Both AND-immediate forms always write it.
- The OR-immediate and XOR-immediate forms never write it.

Source index 0 stands for the constant zero, but only in the two add-immediate forms. An OR-immediate of register 0 with immediate 0 is the canonical no-op and suppresses both the write and the flag update.

Top module: `lxu_top`

## Requirements
- R1: Register forms compute, by `in_op` code: 0 a&b, 1 a|b, 2 a^b, 3 ~(a&b), 4 ~(a|b), 5 ~(a^b), 6 a&~b, 7 a|~b. Each asserts `out_wr_en`.
- R2: For codes 0 to 7 and the sign extensions (codes 14 and 15), `out_cr_wr` follows `rec_bit`.
- R3: Immediate logic uses codes 8/9 for AND, 10/11 for OR and 12/13 for XOR. The even code zero-extends the immediate. The odd code places it in bits 31..16 with zeros below.
- R4: Codes 8 and 9 always assert `out_cr_wr`. Codes 10 to 13 never do, whatever `rec_bit` is.
- R5: Code 14 copies bit 7 into bits 31..8. Code 15 copies bit 15 into bits 31..16.
- R6: Code 16 adds the sign-extended immediate to the base. Code 17 adds the immediate shifted left by 16. In both, the base is zero when `src_a_idx` is 0.
- R7: All logic and extension codes use `src_a` as given, even when `src_a_idx` is 0.
- R8: Code 10 with `src_a_idx` 0 and `imm16` 0 is a no-op: `out_wr_en` and `out_cr_wr` stay low.
- R9: When `out_cr_wr` is high, `out_cr` is {LT, GT, EQ, SO}, bit 3 down to bit 0. Exactly one of LT, GT and EQ is set, from a signed compare of the result with zero. SO copies `so_in`. When `out_cr_wr` is low, `out_cr` is 0.
- R10: Results appear one cycle after `in_valid` with `out_valid` high. Without `in_valid`, and during reset, `out_valid`, `out_wr_en` and `out_cr_wr` are low.
- R11: Codes 18 to 31 give `out_valid` high with `out_wr_en`, `out_cr_wr` and `out_result` all zero.
- R12: Code 17 from index 0 followed by code 10 on that result builds any 32-bit constant, including one whose low half has bit 15 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_op | input | 5 | Decoded operation code |
| src_a | input | 32 | First source value |
| src_b | input | 32 | Second source value |
| src_a_idx | input | 5 | Register index of the first source |
| imm16 | input | 16 | Immediate field |
| rec_bit | input | 1 | Record request |
| so_in | input | 1 | Current summary-overflow bit |
| out_valid | output | 1 | Result strobe |
| out_result | output | 32 | Result value |
| out_wr_en | output | 1 | Destination write enable |
| out_cr_wr | output | 1 | Condition field 0 write enable |
| out_cr | output | 4 | Condition field 0 value |

## Verification
The no-op detection and the flag-rule decision act on the same OR-immediate in the same cycle. The bench therefore issues the no-op with `rec_bit` and `so_in` both high, and requires both enables to stay low. It also issues neighbouring near-no-ops: a nonzero index, and a nonzero immediate. Each of these must write but still raise no flags. Index-zero substitution and register-zero reads are provoked together: add-immediate and OR are issued back to back with index 0 and a nonzero `src_a`. The add must see zero and the OR must see the value.

// File: rtl/lxu_pkg.sv
package lxu_pkg;

    typedef enum logic [4:0] {
        OP_AND     = 5'd0,
        OP_OR      = 5'd1,
        OP_XOR     = 5'd2,
        OP_NAND    = 5'd3,
        OP_NOR     = 5'd4,
        OP_EQV     = 5'd5,
        OP_ANDC    = 5'd6,
        OP_ORC     = 5'd7,
        OP_ANDI_LO = 5'd8,
        OP_ANDI_HI = 5'd9,
        OP_ORI_LO  = 5'd10,
        OP_ORI_HI  = 5'd11,
        OP_XORI_LO = 5'd12,
        OP_XORI_HI = 5'd13,
        OP_EXT_B   = 5'd14,
        OP_EXT_H   = 5'd15,
        OP_ADDI    = 5'd16,
        OP_ADDIS   = 5'd17
    } lxu_op_e;

    localparam logic [4:0] LAST_LEGAL_OP = 5'd17;

    typedef enum logic [1:0] {
        FLG_NEVER  = 2'd0,
        FLG_ALWAYS = 2'd1,
        FLG_RECORD = 2'd2
    } flag_rule_e;

    function automatic flag_rule_e flag_rule(lxu_op_e op);
        flag_rule_e r;
        case (op)
            OP_ANDI_LO, OP_ANDI_HI: r = FLG_ALWAYS;
            OP_ORI_LO, OP_ORI_HI, OP_XORI_LO, OP_XORI_HI,
            OP_ADDI, OP_ADDIS:      r = FLG_NEVER;
            default:                r = FLG_RECORD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lxu_operand.sv
module lxu_operand
    import lxu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int IDX_W = 5
) (
    input  lxu_op_e           op,
    input  logic [XLEN-1:0]   src_a,
    input  logic [IDX_W-1:0]  src_a_idx,
    input  logic [IMM_W-1:0]  imm,
    output logic [XLEN-1:0]   opnd_a,
    output logic [XLEN-1:0]   imm_val
);
    localparam int SEXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_zext;
    logic [XLEN-1:0] imm_high;
    logic [XLEN-1:0] imm_sext;
    logic            base_is_zero;

    always_comb begin
        imm_zext = XLEN'(imm);
        imm_high = imm_zext << IMM_W;
        imm_sext = {{SEXT_W{imm[IMM_W-1]}}, imm};
    end

    always_comb begin
        case (op)
            OP_ANDI_LO, OP_ORI_LO, OP_XORI_LO: imm_val = imm_zext;
            OP_ANDI_HI, OP_ORI_HI, OP_XORI_HI,
            OP_ADDIS:                          imm_val = imm_high;
            OP_ADDI:                           imm_val = imm_sext;
            default:                           imm_val = '0;
        endcase
    end

    // Index zero means "no base" only for the two add-immediate forms.
    always_comb begin
        base_is_zero = ((op == OP_ADDI) || (op == OP_ADDIS)) && (src_a_idx == '0);
        opnd_a       = base_is_zero ? '0 : src_a;
    end

endmodule

// File: rtl/lxu_logic.sv
module lxu_logic
    import lxu_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int BYTE_W = 8,
    parameter int HALF_W = 16
) (
    input  lxu_op_e          op,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    input  logic [XLEN-1:0]  imm_val,
    output logic [XLEN-1:0]  res
);
    localparam int BYTE_PAD = XLEN - BYTE_W;
    localparam int HALF_PAD = XLEN - HALF_W;

    logic [XLEN-1:0] ext_b;
    logic [XLEN-1:0] ext_h;
    logic [XLEN-1:0] sum;

    always_comb begin
        ext_b = {{BYTE_PAD{a[BYTE_W-1]}}, a[BYTE_W-1:0]};
        ext_h = {{HALF_PAD{a[HALF_W-1]}}, a[HALF_W-1:0]};
        sum   = a + imm_val;
    end

    always_comb begin
        case (op)
            OP_AND:                  res = a & b;
            OP_OR:                   res = a | b;
            OP_XOR:                  res = a ^ b;
            OP_NAND:                 res = ~(a & b);
            OP_NOR:                  res = ~(a | b);
            OP_EQV:                  res = ~(a ^ b);
            OP_ANDC:                 res = a & ~b;
            OP_ORC:                  res = a | ~b;
            OP_ANDI_LO, OP_ANDI_HI:  res = a & imm_val;
            OP_ORI_LO, OP_ORI_HI:    res = a | imm_val;
            OP_XORI_LO, OP_XORI_HI:  res = a ^ imm_val;
            OP_EXT_B:                res = ext_b;
            OP_EXT_H:                res = ext_h;
            OP_ADDI, OP_ADDIS:       res = sum;
            default:                 res = '0;
        endcase
    end

endmodule

// File: rtl/lxu_cond.sv
module lxu_cond #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] res,
    input  logic            so,
    output logic [3:0]      cr
);
    logic lt, gt, eq;

    always_comb begin
        lt = res[XLEN-1];
        eq = (res == '0);
        gt = !lt && !eq;
        cr = {lt, gt, eq, so};
    end

endmodule

// File: rtl/lxu_top.sv
module lxu_top
    import lxu_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int IMM_W  = 16,
    parameter int IDX_W  = 5,
    parameter int BYTE_W = 8,
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [4:0]        in_op,
    input  logic [XLEN-1:0]   src_a,
    input  logic [XLEN-1:0]   src_b,
    input  logic [IDX_W-1:0]  src_a_idx,
    input  logic [IMM_W-1:0]  imm16,
    input  logic              rec_bit,
    input  logic              so_in,
    output logic              out_valid,
    output logic [XLEN-1:0]   out_result,
    output logic              out_wr_en,
    output logic              out_cr_wr,
    output logic [3:0]        out_cr
);

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] result;
        logic            wr_en;
        logic            cr_wr;
        logic [3:0]      cr;
    } stage_t;

    lxu_op_e         op_c;
    logic [XLEN-1:0] opnd_a;
    logic [XLEN-1:0] imm_val;
    logic [XLEN-1:0] res_c;
    logic [3:0]      cr_c;
    stage_t          stage_d, stage_q;

    assign op_c = lxu_op_e'(in_op);

    lxu_operand #(.XLEN(XLEN), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_operand (
        .op        (op_c),
        .src_a     (src_a),
        .src_a_idx (src_a_idx),
        .imm       (imm16),
        .opnd_a    (opnd_a),
        .imm_val   (imm_val)
    );

    lxu_logic #(.XLEN(XLEN), .BYTE_W(BYTE_W), .HALF_W(HALF_W)) u_logic (
        .op      (op_c),
        .a       (opnd_a),
        .b       (src_b),
        .imm_val (imm_val),
        .res     (res_c)
    );

    lxu_cond #(.XLEN(XLEN)) u_cond (
        .res (res_c),
        .so  (so_in),
        .cr  (cr_c)
    );

    logic       legal;
    logic       is_nop;
    flag_rule_e rule;
    logic       flag_en;

    always_comb begin
        legal   = (in_op <= LAST_LEGAL_OP);
        rule    = flag_rule(op_c);
        is_nop  = (op_c == OP_ORI_LO) && (src_a_idx == '0) && (imm16 == '0);
        flag_en = legal && ((rule == FLG_ALWAYS) || ((rule == FLG_RECORD) && rec_bit));

        stage_d = '0;
        if (in_valid) begin
            stage_d.valid  = 1'b1;
            stage_d.result = legal ? res_c : '0;
            stage_d.wr_en  = legal && !is_nop;
            stage_d.cr_wr  = flag_en;
            stage_d.cr     = flag_en ? cr_c : 4'b0000;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid  = stage_q.valid;
    assign out_result = stage_q.result;
    assign out_wr_en  = stage_q.wr_en;
    assign out_cr_wr  = stage_q.cr_wr;
    assign out_cr     = stage_q.cr;

    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_wr_en && !out_cr_wr));

    a_r2_plain_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op <= 5'd7) && !rec_bit) |=> !out_cr_wr);

    a_r4_andi_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ((in_op == 5'd8) || (in_op == 5'd9))) |=> out_cr_wr);

    a_r4_orxori_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op >= 5'd10) && (in_op <= 5'd13)) |=> !out_cr_wr);

    a_r8_nop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == 5'd10) && (src_a_idx == '0) && (imm16 == '0))
        |=> (!out_wr_en && !out_cr_wr));

    a_r9_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        out_cr_wr |-> ($countones(out_cr[3:1]) == 1));

    a_r9_lt_sign: assert property (@(posedge clk) disable iff (!rst_n)
        out_cr_wr |-> (out_cr[3] == out_result[XLEN-1]));

    a_r6_addis_zero_base: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == 5'd17) && (src_a_idx == '0))
        |=> (out_result == (XLEN'($past(imm16)) << IMM_W)));

    a_r11_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op > 5'd17)) |=> (!out_wr_en && !out_cr_wr));

endmodule

// File: tb/lxu_top_bench.sv
`timescale 1ns/1ps
module lxu_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  in_op = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [4:0]  src_a_idx = '0;
    logic [15:0] imm16 = '0;
    logic        rec_bit = 1'b0;
    logic        so_in = 1'b0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_wr_en;
    logic        out_cr_wr;
    logic [3:0]  out_cr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    lxu_top u_lxu_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .src_a(src_a), .src_b(src_b), .src_a_idx(src_a_idx), .imm16(imm16),
        .rec_bit(rec_bit), .so_in(so_in), .out_valid(out_valid),
        .out_result(out_result), .out_wr_en(out_wr_en),
        .out_cr_wr(out_cr_wr), .out_cr(out_cr)
    );

    typedef struct {
        logic        valid;
        logic [31:0] result;
        logic        wr;
        logic        crw;
        logic [3:0]  cr;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    // Expected behaviour written from the requirement text.
    function automatic exp_t model(input string tag, input logic v, input logic [4:0] op,
                                   input logic [31:0] a, input logic [31:0] b,
                                   input logic [4:0] idx, input logic [15:0] imm,
                                   input logic rec, input logic so);
        exp_t e;
        logic [31:0] r;
        logic [31:0] base;
        logic fl;
        e.tag = tag; e.valid = v; e.result = '0; e.wr = 0; e.crw = 0; e.cr = '0;
        if (!v) return e;
        base = (idx == 0) ? 32'd0 : a;
        r = '0; fl = 0;
        case (op)
            5'd0: begin r = a & b;    fl = rec; end
            5'd1: begin r = a | b;    fl = rec; end
            5'd2: begin r = a ^ b;    fl = rec; end
            5'd3: begin r = ~(a & b); fl = rec; end
            5'd4: begin r = ~(a | b); fl = rec; end
            5'd5: begin r = ~(a ^ b); fl = rec; end
            5'd6: begin r = a & ~b;   fl = rec; end
            5'd7: begin r = a | ~b;   fl = rec; end
            5'd8:  begin r = a & {16'h0, imm}; fl = 1; end
            5'd9:  begin r = a & {imm, 16'h0}; fl = 1; end
            5'd10: r = a | {16'h0, imm};
            5'd11: r = a | {imm, 16'h0};
            5'd12: r = a ^ {16'h0, imm};
            5'd13: r = a ^ {imm, 16'h0};
            5'd14: begin r = {{24{a[7]}}, a[7:0]};   fl = rec; end
            5'd15: begin r = {{16{a[15]}}, a[15:0]}; fl = rec; end
            5'd16: r = base + {{16{imm[15]}}, imm};
            5'd17: r = base + {imm, 16'h0};
            default: r = '0;
        endcase
        e.result = r;
        e.wr  = (op <= 5'd17) && !(op == 5'd10 && idx == 0 && imm == 0);
        e.crw = (op <= 5'd17) && fl;
        if (e.crw) begin
            e.cr[3] = $signed(r) < 0;
            e.cr[2] = $signed(r) > 0;
            e.cr[1] = (r == 0);
            e.cr[0] = so;
        end
        return e;
    endfunction

    task automatic drv(input string tag, input logic [4:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] idx, input logic [15:0] imm,
                       input logic rec, input logic so);
        @(negedge clk);
        in_valid = 1; in_op = op; src_a = a; src_b = b; src_a_idx = idx;
        imm16 = imm; rec_bit = rec; so_in = so;
        exp_q.push_back(model(tag, 1'b1, op, a, b, idx, imm, rec, so));
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        in_valid = 0; in_op = 5'd3; src_a = 32'hFFFF_FFFF; rec_bit = 1; so_in = 1;
        exp_q.push_back(model(tag, 1'b0, 5'd0, 0, 0, 0, 0, 0, 0));
    endtask

    // Monitor: one expected item per cycle after the edge that registers it.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (out_valid !== e.valid || out_result !== e.result || out_wr_en !== e.wr ||
                    out_cr_wr !== e.crw || out_cr !== e.cr) begin
                    fails++;
                    $display("FAIL %s: got v=%b res=%h wr=%b crw=%b cr=%b exp v=%b res=%h wr=%b crw=%b cr=%b",
                             e.tag, out_valid, out_result, out_wr_en, out_cr_wr, out_cr,
                             e.valid, e.result, e.wr, e.crw, e.cr);
                end
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got hang exp completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 0 || out_wr_en !== 0 || out_cr_wr !== 0) begin
            fails++;
            $display("FAIL R10 reset: got v=%b wr=%b crw=%b exp 0 0 0", out_valid, out_wr_en, out_cr_wr);
        end
        rst_n = 1;

        // R1: all eight register forms, two data patterns, no record
        for (int k = 0; k < 8; k++)
            drv("R1 pattern A", 5'(k), 32'hF0F0_1234, 32'h0FF0_8765, 5'd4, 16'h0, 0, 0);
        for (int k = 0; k < 8; k++)
            drv("R1 pattern B", 5'(k), 32'h8000_0001, 32'hFFFF_0000, 5'd9, 16'h0, 0, 1);
        // R2 / R9: record variants giving zero, negative, positive
        drv("R2 R9 and zero EQ", 5'd0, 32'hAAAA_AAAA, 32'h5555_5555, 5'd2, 0, 1, 0);
        drv("R2 R9 or negative LT SO", 5'd1, 32'h8000_0000, 32'h1, 5'd2, 0, 1, 1);
        drv("R2 R9 orc positive GT", 5'd7, 32'h0000_0010, 32'hFFFF_FFF0, 5'd2, 0, 1, 0);
        drv("R2 plain nor untouched", 5'd4, 32'h0, 32'h0, 5'd2, 0, 0, 1);
        // R3 / R4: immediate forms with record bit set and clear
        drv("R3 R4 andi lo", 5'd8, 32'hFFFF_8001, 0, 5'd1, 16'h8003, 0, 0);
        drv("R3 R4 andi hi zero", 5'd9, 32'h0000_FFFF, 0, 5'd1, 16'hFFFF, 0, 1);
        drv("R3 R4 ori lo rec ignored", 5'd10, 32'h8000_0000, 0, 5'd1, 16'h8000, 1, 1);
        drv("R3 R4 ori hi", 5'd11, 32'h0000_0001, 0, 5'd1, 16'hC000, 1, 0);
        drv("R3 R4 xori lo", 5'd12, 32'h1234_FFFF, 0, 5'd1, 16'hFFFF, 1, 0);
        drv("R3 R4 xori hi", 5'd13, 32'hFFFF_0000, 0, 5'd1, 16'hFFFF, 0, 0);
        // R5: sign extension both polarities, record and plain
        drv("R5 extb neg rec", 5'd14, 32'h1234_5680, 0, 5'd3, 0, 1, 0);
        drv("R5 extb pos", 5'd14, 32'hFFFF_FF7F, 0, 5'd3, 0, 0, 0);
        drv("R5 exth neg", 5'd15, 32'h0000_8000, 0, 5'd3, 0, 1, 1);
        drv("R5 exth pos rec", 5'd15, 32'hFFFF_7FFF, 0, 5'd3, 0, 1, 0);
        // R6 / R7: index zero substitution only for add forms
        drv("R6 addi idx0", 5'd16, 32'h0000_1234, 0, 5'd0, 16'hFFFF, 1, 0);
        drv("R7 or idx0 reads value", 5'd1, 32'hAAAA_0000, 32'h0000_5555, 5'd0, 0, 0, 0);
        drv("R6 addi base", 5'd16, 32'd100, 0, 5'd3, 16'h8000, 0, 0);
        drv("R6 addis idx0", 5'd17, 32'hDEAD_BEEF, 0, 5'd0, 16'h1234, 1, 0);
        drv("R6 addis base", 5'd17, 32'h0000_0010, 0, 5'd5, 16'hFFFF, 0, 0);
        drv("R7 extb idx0", 5'd14, 32'h0000_00FF, 0, 5'd0, 0, 0, 0);
        // R8: canonical no-op and its near neighbours
        drv("R8 nop", 5'd10, 32'h0000_0042, 0, 5'd0, 16'h0, 1, 1);
        drv("R8 idx1 writes", 5'd10, 32'h0000_0042, 0, 5'd1, 16'h0, 1, 1);
        drv("R8 imm1 writes", 5'd10, 32'h0000_0042, 0, 5'd0, 16'h1, 1, 1);
        // R10: idle gaps carry nothing
        idle("R10 idle 1");
        idle("R10 idle 2");
        drv("R10 after gap", 5'd2, 32'h1, 32'h3, 5'd1, 0, 1, 0);
        // R11: undefined codes
        drv("R11 code 18", 5'd18, 32'hFFFF_FFFF, 32'h1, 5'd1, 16'h1, 1, 1);
        drv("R11 code 31", 5'd31, 32'h1, 32'h1, 5'd0, 16'h0, 1, 0);
        // R12: two-step constant build
        drv("R12 hi 12348765", 5'd17, 32'hFFFF_FFFF, 0, 5'd0, 16'h1234, 0, 0);
        drv("R12 lo 12348765", 5'd10, 32'h1234_0000, 0, 5'd7, 16'h8765, 0, 0);
        drv("R12 hi DEADBEEF", 5'd17, 32'h0, 0, 5'd0, 16'hDEAD, 0, 0);
        drv("R12 lo DEADBEEF", 5'd10, 32'hDEAD_0000, 0, 5'd7, 16'hBEEF, 0, 0);
        idle("R10 final idle");
        idle("R10 final idle 2");

        wait (exp_q.size() == 0);
        @(posedge clk); #1;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule